// File: doc/BRIEF.md
# Filtered External Interrupt Detector

This block turns a set of asynchronous input pins into per-channel interrupt requests. Each pin is first brought into the clock domain by a two-stage synchronizer. A small mapping table then routes pins onto interrupt channels. On each channel, an optional run-length noise filter can clean the level. A trigger stage then watches for a low level, a falling edge, a rising edge or either edge.

Edge triggers set a sticky pending flag that software clears by writing a one. A low-level trigger drives the request for as long as the observed level stays low. The filter samples at one of four rates, derived from the clock by a shared strobe generator: every cycle, every 8th, every 32nd or every 64th cycle. A new level passes only when three consecutive samples agree.

A simple register port configures the block. Writes are one-cycle strobes and reads are combinational. Through it software sets each channel's trigger, filter enable and rate, maps pins to channels, clears pending flags, and reads a status that reports channels claimed by more than one pin.

Top module: `extint_filter_top`

## Requirements
- R1: After reset, every pending flag and request is 0. Every channel control reads 0x01 (falling edge, filter off, rate 0). Pin p is mapped and enabled to channel p, so map register p reads 0x80|p. The conflict status reads 0.
- R2: Control field bits [1:0] = 01 selects the falling trigger. A high-to-low change of the observed level sets the channel's pending flag. A low-to-high change does not. The request output equals the pending flag.
- R3: Trigger code 10 selects the rising trigger. A low-to-high change sets pending. A high-to-low change does not.
- R4: Trigger code 11 selects both edges. Either change of the observed level sets pending.
- R5: Trigger code 00 selects the low-level trigger. The request is 1 exactly while the observed level is low. The pending flag is never set in this mode.
- R6: A pending flag stays set until a write to the pending address (0x8) has a 1 in that channel's bit. Writing 0 in that bit leaves it set.
- R7: With the filter bit (control bit 2) set, the observed level is the filtered one. The filter samples on strobes at clock/1, /8, /32 or /64 for rate field bits [4:3] = 0, 1, 2, 3. It changes level only after three consecutive samples agree. A pulse shorter than 2 sample periods is removed, and one of 4 sample periods or more passes.
- R8: With the filter bit clear, the synchronized pin is observed every clock cycle, so a single-cycle pulse is detected.
- R9: Map register p (address 0x4+p) holds an enable in bit 7 and a channel number in bits [1:0]. When several enabled pins name one channel, only the lowest-numbered pin drives it and the others are ignored. The channel's bit in the conflict status (address 0xC) then reads 1. A channel with no enabled pin sees an idle high level.
- R10: Any write to a channel's control register clears its edge history. A change of the observed level caused by the new settings raises no edge.
- R11: Control registers (address 0x0+c, bits [4:0]) and map registers read back the values last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins, idle high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address: bits [3:2] region, low bits index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | NUM_CH | Per-channel interrupt request |
| pend_o | output | NUM_CH | Per-channel sticky pending flag |

## Verification
If the filter history or the divided strobes are wrong, pulses near the two- and four-sample limits go the wrong way. That shows on pend_o within a few sample periods of the pulse, which at the slowest rate means a few hundred cycles. If the edge history is wrong, pend_o rises on the cycle after a control write with no pin activity, or stays low two cycles after a real transition. Routing faults show as a pending flag on the wrong channel, or as a conflict bit that disagrees with the map just written.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_e;

    // packed MSB first: rate [4:3], filter enable [2], trigger [1:0]
    typedef struct packed {
        logic [1:0] rate;
        logic       flt_en;
        trig_e      mode;
    } chan_cfg_t;

    localparam int CFG_W = 5;

    localparam logic [1:0] RGN_CTRL = 2'd0;
    localparam logic [1:0] RGN_MAP  = 2'd1;
    localparam logic [1:0] RGN_PEND = 2'd2;
    localparam logic [1:0] RGN_CONF = 2'd3;

    localparam chan_cfg_t CFG_RESET = '{rate: 2'd0, flt_en: 1'b0, mode: TRIG_FALL};

    function automatic logic edge_fires(input trig_e m, input logic prev, input logic cur);
        logic r;
        case (m)
            TRIG_FALL: r = prev & ~cur;
            TRIG_RISE: r = ~prev & cur;
            TRIG_BOTH: r = prev ^ cur;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/extint_strobe_gen.sv
module extint_strobe_gen #(
    parameter int SH1 = 3,
    parameter int SH2 = 5,
    parameter int SH3 = 6
) (
    input  logic       clk,
    input  logic       rst,
    output logic [3:0] stb_o
);
    localparam int CNT_W = SH3;
    localparam int SHIFTS [3] = '{SH1, SH2, SH3};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign stb_o[0] = 1'b1;

    for (genvar g = 0; g < 3; g++) begin : g_div
        assign stb_o[g+1] = &cnt_q[SHIFTS[g]-1:0];
    end

    // R7
    div_gap_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o[1] |=> !stb_o[1]);

endmodule

// File: rtl/extint_router.sv
module extint_router #(
    parameter int NUM_CH   = 4,
    parameter int NUM_PINS = 4,
    parameter int CH_W     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_sync_i,
    input  logic [NUM_PINS-1:0] map_en_i,
    input  logic [CH_W-1:0]     map_ch_i [NUM_PINS],
    output logic [NUM_CH-1:0]   lvl_o,
    output logic [NUM_CH-1:0]   conflict_o
);
    localparam int CNT_W = $clog2(NUM_PINS + 1);

    logic [NUM_CH-1:0] conflict_d, conflict_q;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            logic            found;
            logic [CNT_W-1:0] hits;
            found    = 1'b0;
            hits     = '0;
            lvl_o[c] = 1'b1;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (map_en_i[p] && map_ch_i[p] == CH_W'(c)) begin
                    hits = hits + 1'b1;
                    if (!found) begin
                        lvl_o[c] = pin_sync_i[p];
                        found    = 1'b1;
                    end
                end
            end
            conflict_d[c] = (hits > CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) conflict_q <= '0;
        else     conflict_q <= conflict_d;
    end

    assign conflict_o = conflict_q;

    // R9
    conf_need_two_chk: assert property (@(posedge clk) disable iff (rst)
        (|conflict_q) |-> $past($countones(map_en_i) > 1));

endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_PINS = 4,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 2,
    parameter int CH_W     = 2,
    parameter int ADDR_W   = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_CH-1:0]   pend_i,
    input  logic [NUM_CH-1:0]   conflict_i,
    output chan_cfg_t           cfg_o    [NUM_CH],
    output logic [NUM_CH-1:0]   cfg_wr_o,
    output logic [NUM_CH-1:0]   clr_o,
    output logic [NUM_PINS-1:0] map_en_o,
    output logic [CH_W-1:0]     map_ch_o [NUM_PINS]
);
    logic [1:0]       rgn;
    logic [IDX_W-1:0] idx;
    logic             unused_wdata;

    assign rgn          = bus_addr[ADDR_W-1 -: 2];
    assign idx          = bus_addr[IDX_W-1:0];
    assign unused_wdata = ^bus_wdata;

    chan_cfg_t        ctrl_q [NUM_CH];
    logic [CH_W-1:0]  mch_q  [NUM_PINS];
    logic [NUM_PINS-1:0] men_q;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            cfg_wr_o[c] = bus_wr && rgn == RGN_CTRL && idx == IDX_W'(c);
        clr_o = (bus_wr && rgn == RGN_PEND) ? bus_wdata[NUM_CH-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) ctrl_q[c] <= CFG_RESET;
            for (int p = 0; p < NUM_PINS; p++) begin
                men_q[p] <= 1'b1;
                mch_q[p] <= CH_W'(p % NUM_CH);
            end
        end else if (bus_wr) begin
            for (int c = 0; c < NUM_CH; c++)
                if (cfg_wr_o[c]) ctrl_q[c] <= chan_cfg_t'(bus_wdata[CFG_W-1:0]);
            for (int p = 0; p < NUM_PINS; p++)
                if (rgn == RGN_MAP && idx == IDX_W'(p)) begin
                    men_q[p] <= bus_wdata[DATA_W-1];
                    mch_q[p] <= bus_wdata[CH_W-1:0];
                end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (rgn)
            RGN_CTRL: for (int c = 0; c < NUM_CH; c++)
                          if (idx == IDX_W'(c)) bus_rdata = DATA_W'(ctrl_q[c]);
            RGN_MAP:  for (int p = 0; p < NUM_PINS; p++)
                          if (idx == IDX_W'(p)) begin
                              bus_rdata[DATA_W-1] = men_q[p];
                              bus_rdata[CH_W-1:0] = mch_q[p];
                          end
            RGN_PEND: bus_rdata = DATA_W'(pend_i);
            default:  bus_rdata = DATA_W'(conflict_i);
        endcase
    end

    assign cfg_o    = ctrl_q;
    assign map_en_o = men_q;
    assign map_ch_o = mch_q;

endmodule

// File: rtl/extint_chan.sv
module extint_chan
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_i,
    input  logic [3:0] stb_i,
    input  chan_cfg_t  cfg_i,
    input  logic       cfg_wr_i,
    input  logic       clr_i,
    output logic       irq_o,
    output logic       pend_o
);
    logic [1:0] hist_q;
    logic       filt_q;
    logic       prev_q;
    logic       quiet_q;
    logic       pend_q;
    logic       stb_sel;
    logic       det;
    logic       hit;
    logic       lvl_mode;

    assign stb_sel  = stb_i[cfg_i.rate];
    assign lvl_mode = (cfg_i.mode == TRIG_LOW);

    // run-length filter: always tracks the pin at the selected rate
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 2'b11;
            filt_q <= 1'b1;
        end else if (stb_sel) begin
            hist_q <= {hist_q[0], lvl_i};
            if (lvl_i == hist_q[0] && lvl_i == hist_q[1]) filt_q <= lvl_i;
        end
    end

    assign det = cfg_i.flt_en ? filt_q : lvl_i;
    assign hit = !quiet_q && edge_fires(cfg_i.mode, prev_q, det);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            quiet_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            prev_q  <= det;
            quiet_q <= cfg_wr_i;
            if (hit)        pend_q <= 1'b1;
            else if (clr_i) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = lvl_mode ? ~det : pend_q;

    // R7
    flt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> ($past(stb_sel) && $past(lvl_i) == filt_q));

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        quiet_q |=> !$rose(pend_q));

    // R6
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hit) |=> !pend_q);

    // R5
    level_nopend_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> !$past(lvl_mode));

endmodule

// File: rtl/extint_filter_top.sv
module extint_filter_top
    import extint_pkg::*;
#(
    parameter  int NUM_CH   = 4,
    parameter  int NUM_PINS = 4,
    parameter  int DATA_W   = 8,
    parameter  int SH1      = 3,
    parameter  int SH2      = 5,
    parameter  int SH3      = 6,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int IDX_W    = (CH_W > PIN_W) ? CH_W : PIN_W,
    localparam int ADDR_W   = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CH-1:0]   irq_o,
    output logic [NUM_CH-1:0]   pend_o
);
    logic [NUM_PINS-1:0] s1_q, s2_q;
    logic [3:0]          stb;
    logic [NUM_CH-1:0]   lvl, conflict, cfg_wr, clr;
    logic [NUM_PINS-1:0] map_en;
    logic [CH_W-1:0]     map_ch [NUM_PINS];
    chan_cfg_t           cfg    [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
        end
    end

    extint_strobe_gen #(.SH1(SH1), .SH2(SH2), .SH3(SH3)) u_stb (
        .clk   (clk),
        .rst   (rst),
        .stb_o (stb)
    );

    extint_router #(.NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS), .CH_W(CH_W)) u_route (
        .clk        (clk),
        .rst        (rst),
        .pin_sync_i (s2_q),
        .map_en_i   (map_en),
        .map_ch_i   (map_ch),
        .lvl_o      (lvl),
        .conflict_o (conflict)
    );

    extint_regs #(
        .NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .CH_W(CH_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pend_i     (pend_o),
        .conflict_i (conflict),
        .cfg_o      (cfg),
        .cfg_wr_o   (cfg_wr),
        .clr_o      (clr),
        .map_en_o   (map_en),
        .map_ch_o   (map_ch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        extint_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .lvl_i    (lvl[c]),
            .stb_i    (stb),
            .cfg_i    (cfg[c]),
            .cfg_wr_i (cfg_wr[c]),
            .clr_i    (clr[c]),
            .irq_o    (irq_o[c]),
            .pend_o   (pend_o[c])
        );
    end

endmodule

// File: tb/test_extint_filter_top.sv
module test_extint_filter_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_i = 4'hF;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] irq_o, pend_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    extint_filter_top i_extint_filter_top (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .pend_o    (pend_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [7:0] d;
        tick(5);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        chk("R1 pend", pend_o, 0);
        chk("R1 irq", irq_o, 0);
        rd(4'h0, d); chk("R1 ctrl0", d, 8'h01);
        rd(4'h5, d); chk("R1 map1", d, 8'h81);
        rd(4'hC, d); chk("R1 conflict", d, 0);

        // R2 R3 R4 R5 sweep: every channel, every trigger, unfiltered
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 4; m++) begin
                string req;
                int    fall_p, rise_p;
                req    = (m == 0) ? "R5" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
                fall_p = (m == 1 || m == 3) ? 1 : 0;
                rise_p = (m == 2 || m == 3) ? 1 : 0;
                wr(4'(c), 8'(m));
                wr(4'h8, 8'h0F);
                tick(4);
                pin_i[c] = 1'b0;
                tick(5);
                chk({req, " pend after fall"}, pend_o, fall_p << c);
                chk({req, " irq while low"}, irq_o[c], (m == 0) ? 1 : fall_p);
                wr(4'h8, 8'h0F);
                pin_i[c] = 1'b1;
                tick(5);
                chk({req, " pend after rise"}, pend_o, rise_p << c);
                chk({req, " irq while high"}, irq_o[c], (m == 0) ? 0 : rise_p);
            end
        end

        // R6 sticky pending and write-one clear
        wr(4'h0, 8'h01);
        wr(4'h8, 8'h0F);
        tick(3);
        pin_i[0] = 1'b0; tick(4); pin_i[0] = 1'b1; tick(4);
        chk("R6 set", pend_o[0], 1);
        wr(4'h8, 8'h0E);
        tick(20);
        chk("R6 write zero keeps", pend_o[0], 1);
        rd(4'h8, d); chk("R6 readback", d[0], 1);
        wr(4'h8, 8'h01);
        tick(1);
        chk("R6 write one clears", pend_o[0], 0);

        // R8 single-cycle pulse without filter
        pin_i[0] = 1'b0; tick(1); pin_i[0] = 1'b1; tick(5);
        chk("R8 one-cycle pulse", pend_o[0], 1);
        wr(4'h8, 8'h01);

        // R7 filter at each rate
        for (int r = 0; r < 4; r++) begin
            int dv;
            dv = (r == 0) ? 1 : (r == 1) ? 8 : (r == 2) ? 32 : 64;
            wr(4'h0, 8'(8'h05 | (r << 3)));
            tick(4 * dv + 4);
            wr(4'h8, 8'h01);
            pin_i[0] = 1'b0; tick(2 * dv - 1); pin_i[0] = 1'b1;
            tick(4 * dv + 8);
            chk($sformatf("R7 short pulse rate %0d", r), pend_o[0], 0);
            pin_i[0] = 1'b0; tick(4 * dv); pin_i[0] = 1'b1;
            tick(4);
            chk($sformatf("R7 long pulse rate %0d", r), pend_o[0], 1);
            tick(4 * dv + 8);
            wr(4'h8, 8'h01);
        end

        // R9 two pins on one channel
        wr(4'h0, 8'h01);
        wr(4'h1, 8'h01);
        wr(4'h5, 8'h80);
        tick(2);
        rd(4'hC, d); chk("R9 conflict set", d, 8'h01);
        wr(4'h8, 8'h0F);
        pin_i[1] = 1'b0; tick(6); pin_i[1] = 1'b1; tick(6);
        chk("R9 second pin ignored", pend_o, 0);
        pin_i[0] = 1'b0; tick(6); pin_i[0] = 1'b1; tick(6);
        chk("R9 first pin wins", pend_o, 4'b0001);
        wr(4'h5, 8'h81);
        tick(2);
        rd(4'hC, d); chk("R9 conflict cleared", d, 0);
        rd(4'h5, d); chk("R11 map readback", d, 8'h81);
        wr(4'h8, 8'h0F);

        // R10 enabling the filter flips the observed level without an edge
        wr(4'h2, 8'h1A);
        tick(300);
        wr(4'h8, 8'h0F);
        pin_i[2] = 1'b0;
        tick(5);
        chk("R10 rising mode ignores fall", pend_o[2], 0);
        wr(4'h2, 8'h1E);
        tick(6);
        chk("R10 no spurious edge", pend_o[2], 0);
        rd(4'h2, d); chk("R11 ctrl readback", d, 8'h1E);
        tick(300);
        pin_i[2] = 1'b1;
        tick(300);
        chk("R10 real rise after filter", pend_o[2], 1);

        summary();
    end

endmodule